// File: doc/BRIEF.md
# AXI-Lite Width Up-Converter

This block joins an AXI-Lite master whose data bus is narrow to an AXI-Lite slave whose data bus is wider by a power-of-two factor. Every narrow transaction turns into exactly one wide transaction. The slave always sees an address rounded down to the wide word. Narrow write data and strobes are moved into the lane that the low address bits pick. The rest of the wide word is driven with zero data and zero strobe.

On a read, the whole wide word is fetched from the slave, and the lane selected by the captured address goes back to the master. The write path and the read path each run their own small state machine. A write can therefore finish while a read is still waiting on the slave, and the reverse also holds.

Each path holds at most one transaction in flight. No merging, caching or burst handling is done. Two narrow writes to the same wide word reach the slave as two separate writes, each with a partial strobe.

Top module: `axil_upsizer`

## Requirements
- R1: The slave write and read addresses equal the master address with the low log2(WIDE_W/8) bits cleared; for example, 0x102 becomes 0x100 when the bus goes from 16 to 32 bits.
- R2: The lane index is the address slice [log2(WIDE_W/8)-1 : log2(NARROW_W/8)], which is bit 1 for 16 to 32 bits. Lane k occupies slave data bits [k*NARROW_W +: NARROW_W], and the narrow write data appears there with zeros in every other lane.
- R3: The narrow strobe is copied bit for bit into slave strobe bits [k*NARROW_W/8 +: NARROW_W/8], and all other strobe bits are zero. A strobe of 0b01 in lane 1 becomes 0b0100.
- R4: Each accepted narrow write produces exactly one wide write, and each accepted narrow read produces exactly one wide read, even when consecutive reads fall in the same wide word.
- R5: The master read data is lane k of the returned wide word, where k comes from the read address captured when the request was accepted. Requests that arrive out of address order still map to the correct lanes.
- R6: The 2-bit write and read response codes reach the master unchanged.
- R7: The read and write paths run independently, so a write completes while a read response is still pending from the slave.
- R8: A path accepts no new request until the response of its current transaction has been handed to the master.
- R9: After reset, m_awready, m_wready and m_arready are 1, and every valid output on both sides is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_awaddr | input | ADDR_W | Master write address |
| m_awvalid | input | 1 | Master write address valid |
| m_awready | output | 1 | Master write address ready |
| m_wdata | input | NARROW_W | Master write data |
| m_wstrb | input | NARROW_W/8 | Master write strobe |
| m_wvalid | input | 1 | Master write data valid |
| m_wready | output | 1 | Master write data ready |
| m_bresp | output | 2 | Master write response code |
| m_bvalid | output | 1 | Master write response valid |
| m_bready | input | 1 | Master write response ready |
| m_araddr | input | ADDR_W | Master read address |
| m_arvalid | input | 1 | Master read address valid |
| m_arready | output | 1 | Master read address ready |
| m_rdata | output | NARROW_W | Master read data |
| m_rresp | output | 2 | Master read response code |
| m_rvalid | output | 1 | Master read data valid |
| m_rready | input | 1 | Master read data ready |
| s_awaddr | output | ADDR_W | Slave write address, wide-aligned |
| s_awvalid | output | 1 | Slave write address valid |
| s_awready | input | 1 | Slave write address ready |
| s_wdata | output | WIDE_W | Slave write data, lane-placed |
| s_wstrb | output | WIDE_W/8 | Slave write strobe, lane-placed |
| s_wvalid | output | 1 | Slave write data valid |
| s_wready | input | 1 | Slave write data ready |
| s_bresp | input | 2 | Slave write response code |
| s_bvalid | input | 1 | Slave write response valid |
| s_bready | output | 1 | Slave write response ready |
| s_araddr | output | ADDR_W | Slave read address, wide-aligned |
| s_arvalid | output | 1 | Slave read address valid |
| s_arready | input | 1 | Slave read address ready |
| s_rdata | input | WIDE_W | Slave read data |
| s_rresp | input | 2 | Slave read response code |
| s_rvalid | input | 1 | Slave read data valid |
| s_rready | output | 1 | Slave read data ready |

## Verification
The assertions assume two things about the slave. It raises a response only for a request it has already accepted, and it keeps that response valid until the converter takes it. The assertions also assume the master keeps an address valid until it is accepted. The bench's slave model answers only the single request it has captured, and it holds bvalid and rvalid until it sees ready. It also varies its ready latency between 0 and 2 cycles, so the hold and one-request-per-acceptance properties are exercised under back-pressure. The master tasks keep each valid raised until its handshake, and they hold a path idle until its response has been consumed.

// File: rtl/axil_upsizer.sv
module axil_upsizer #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     m_awaddr,
  input  logic                  m_awvalid,
  output logic                  m_awready,
  input  logic [NARROW_W-1:0]   m_wdata,
  input  logic [NARROW_W/8-1:0] m_wstrb,
  input  logic                  m_wvalid,
  output logic                  m_wready,
  output logic [1:0]            m_bresp,
  output logic                  m_bvalid,
  input  logic                  m_bready,
  input  logic [ADDR_W-1:0]     m_araddr,
  input  logic                  m_arvalid,
  output logic                  m_arready,
  output logic [NARROW_W-1:0]   m_rdata,
  output logic [1:0]            m_rresp,
  output logic                  m_rvalid,
  input  logic                  m_rready,
  output logic [ADDR_W-1:0]     s_awaddr,
  output logic                  s_awvalid,
  input  logic                  s_awready,
  output logic [WIDE_W-1:0]     s_wdata,
  output logic [WIDE_W/8-1:0]   s_wstrb,
  output logic                  s_wvalid,
  input  logic                  s_wready,
  input  logic [1:0]            s_bresp,
  input  logic                  s_bvalid,
  output logic                  s_bready,
  output logic [ADDR_W-1:0]     s_araddr,
  output logic                  s_arvalid,
  input  logic                  s_arready,
  input  logic [WIDE_W-1:0]     s_rdata,
  input  logic [1:0]            s_rresp,
  input  logic                  s_rvalid,
  output logic                  s_rready
);
  localparam int NB     = NARROW_W / 8;
  localparam int WB     = WIDE_W / 8;
  localparam int LANES  = WIDE_W / NARROW_W;
  localparam int LSEL_W = $clog2(LANES);
  localparam int NLSB   = $clog2(NB);
  localparam int WLSB   = $clog2(WB);

  typedef enum logic [1:0] {COLLECT, ISSUE, RESP} wr_st_t;
  typedef enum logic [1:0] {R_IDLE, R_ISSUE, R_WAIT} rd_st_t;

  // write path
  wr_st_t            wr_st;
  logic              aw_f, w_f;
  logic [ADDR_W-1:0] wa_q;
  logic [NARROW_W-1:0] wd_q;
  logic [NB-1:0]     ws_q;
  logic [LSEL_W-1:0] w_lane;

  assign m_awready = (wr_st == COLLECT) && !aw_f;
  assign m_wready  = (wr_st == COLLECT) && !w_f;
  assign s_awvalid = (wr_st == ISSUE) && !aw_f;
  assign s_wvalid  = (wr_st == ISSUE) && !w_f;
  assign m_bvalid  = (wr_st == RESP) && s_bvalid;
  assign s_bready  = (wr_st == RESP) && m_bready;
  assign m_bresp   = s_bresp;
  assign s_awaddr  = {wa_q[ADDR_W-1:WLSB], {WLSB{1'b0}}};
  assign w_lane    = wa_q[WLSB-1:NLSB];

  for (genvar i = 0; i < LANES; i++) begin : g_wlane
    assign s_wdata[i*NARROW_W +: NARROW_W] = (w_lane == LSEL_W'(i)) ? wd_q : '0;
    assign s_wstrb[i*NB +: NB]             = (w_lane == LSEL_W'(i)) ? ws_q : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_st <= COLLECT;
      aw_f  <= 1'b0;
      w_f   <= 1'b0;
      wa_q  <= '0;
      wd_q  <= '0;
      ws_q  <= '0;
    end else begin
      case (wr_st)
        COLLECT: begin
          if (m_awvalid && m_awready) begin
            aw_f <= 1'b1;
            wa_q <= m_awaddr;
          end
          if (m_wvalid && m_wready) begin
            w_f  <= 1'b1;
            wd_q <= m_wdata;
            ws_q <= m_wstrb;
          end
          if ((aw_f || m_awvalid) && (w_f || m_wvalid)) begin
            wr_st <= ISSUE;
            aw_f  <= 1'b0;
            w_f   <= 1'b0;
          end
        end
        ISSUE: begin
          if (s_awvalid && s_awready) aw_f <= 1'b1;
          if (s_wvalid && s_wready)   w_f  <= 1'b1;
          if ((aw_f || s_awready) && (w_f || s_wready)) begin
            wr_st <= RESP;
            aw_f  <= 1'b0;
            w_f   <= 1'b0;
          end
        end
        default: if (s_bvalid && m_bready) wr_st <= COLLECT;
      endcase
    end
  end

  // read path
  rd_st_t            rd_st;
  logic [ADDR_W-1:0] ra_q;
  logic [LSEL_W-1:0] r_lane;

  assign m_arready = (rd_st == R_IDLE);
  assign s_arvalid = (rd_st == R_ISSUE);
  assign m_rvalid  = (rd_st == R_WAIT) && s_rvalid;
  assign s_rready  = (rd_st == R_WAIT) && m_rready;
  assign m_rresp   = s_rresp;
  assign s_araddr  = {ra_q[ADDR_W-1:WLSB], {WLSB{1'b0}}};
  assign r_lane    = ra_q[WLSB-1:NLSB];

  always_comb begin
    m_rdata = '0;
    for (int i = 0; i < LANES; i++)
      if (r_lane == LSEL_W'(i)) m_rdata = s_rdata[i*NARROW_W +: NARROW_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_st <= R_IDLE;
      ra_q  <= '0;
    end else begin
      case (rd_st)
        R_IDLE:  if (m_arvalid) begin
                   rd_st <= R_ISSUE;
                   ra_q  <= m_araddr;
                 end
        R_ISSUE: if (s_arready) rd_st <= R_WAIT;
        default: if (s_rvalid && m_rready) rd_st <= R_IDLE;
      endcase
    end
  end

  // checks
  logic [LANES-1:0] lane_any;
  for (genvar i = 0; i < LANES; i++) begin : g_lany
    assign lane_any[i] = |s_wstrb[i*NB +: NB];
  end

  p_aw_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_awvalid |-> (s_awaddr[WLSB-1:0] == '0));
  p_ar_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_arvalid && !s_arready |=> s_arvalid && $stable(s_araddr));
  p_strb_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_wvalid |-> $onehot0(lane_any));
  p_one_wide_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_arvalid && s_arready |=> !s_arvalid);
  p_one_wide_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_awvalid && s_awready |=> !s_awvalid);
  p_rd_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && m_arready |=> !m_arready);
  p_wr_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && m_awready |=> !m_awready);
endmodule

// File: tb/test_axil_upsizer.sv
module test_axil_upsizer;
  localparam int AW = 32, NW = 16, WW = 32;
  localparam int NB = NW / 8, WB = WW / 8, NLSB = $clog2(NB);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] m_awaddr = '0, m_araddr = '0, s_awaddr, s_araddr;
  logic m_awvalid = 0, m_awready, m_wvalid = 0, m_wready, m_bvalid, m_bready = 0;
  logic [NW-1:0] m_wdata = '0, m_rdata;
  logic [NB-1:0] m_wstrb = '0;
  logic [1:0] m_bresp, m_rresp, s_bresp = '0, s_rresp = '0;
  logic m_arvalid = 0, m_arready, m_rvalid, m_rready = 0;
  logic s_awvalid, s_awready = 0, s_wvalid, s_wready = 0, s_bvalid = 0, s_bready;
  logic [WW-1:0] s_wdata, s_rdata = '0;
  logic [WB-1:0] s_wstrb;
  logic s_arvalid, s_arready = 0, s_rvalid = 0, s_rready;

  axil_upsizer #(.ADDR_W(AW), .NARROW_W(NW), .WIDE_W(WW)) i_axil_upsizer (.*);

  int n_chk = 0, n_bad = 0, n_swr = 0, n_srd = 0, n_mwr = 0, n_mrd = 0;
  bit rd_stall = 0, rd_busy = 0;
  typedef struct {logic [AW-1:0] a; logic [WW-1:0] d; logic [WB-1:0] s;} wexp_t;
  wexp_t wq[$];
  logic [AW-1:0] arq[$];

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] align(logic [AW-1:0] a);
    return a & ~AW'(WB - 1);
  endfunction
  function automatic int lane_of(logic [AW-1:0] a);
    return int'((a >> NLSB) & AW'(WW / NW - 1));
  endfunction
  function automatic logic [WW-1:0] rfn(logic [AW-1:0] a);
    return WW'(a * 32'h0001_0003) ^ 32'hc3a5_5a3c;
  endfunction
  function automatic logic [1:0] resp_of(logic [AW-1:0] a);
    return a[9:8];
  endfunction

  task automatic m_write(logic [AW-1:0] a, logic [NW-1:0] d, logic [NB-1:0] s);
    wexp_t e;
    bit aw_d = 0, w_d = 0, got = 0;
    e.a = align(a);
    e.d = WW'(d) << (lane_of(a) * NW);
    e.s = WB'(s) << (lane_of(a) * NB);
    wq.push_back(e);
    n_mwr++;
    @(negedge clk);
    m_awaddr = a; m_awvalid = 1; m_wdata = d; m_wstrb = s; m_wvalid = 1;
    while (!(aw_d && w_d)) begin
      #1;
      if (m_awvalid && m_awready) aw_d = 1;
      if (m_wvalid && m_wready) w_d = 1;
      @(negedge clk);
      if (aw_d) m_awvalid = 0;
      if (w_d) m_wvalid = 0;
    end
    m_bready = 1;
    while (!got) begin
      #1;
      got = m_bvalid;
      if (got) chk(m_bresp == resp_of(e.a), "R6 bresp", m_bresp, resp_of(e.a));
      @(negedge clk);
    end
    m_bready = 0;
  endtask

  task automatic m_read(logic [AW-1:0] a);
    bit ar_d = 0, got = 0;
    logic [NW-1:0] exp_d;
    exp_d = NW'(rfn(align(a)) >> (lane_of(a) * NW));
    arq.push_back(align(a));
    n_mrd++;
    rd_busy = 1;
    @(negedge clk);
    m_araddr = a; m_arvalid = 1;
    while (!ar_d) begin
      #1;
      ar_d = m_arready;
      @(negedge clk);
      if (ar_d) begin m_arvalid = 0; m_araddr = '1; end
    end
    m_rready = 1;
    while (!got) begin
      #1;
      got = m_rvalid;
      if (got) begin
        chk(m_rdata == exp_d, "R5 rdata lane", m_rdata, exp_d);
        chk(m_rresp == resp_of(align(a)), "R6 rresp", m_rresp, resp_of(align(a)));
      end
      @(negedge clk);
    end
    m_rready = 0;
    rd_busy = 0;
  endtask

  // slave write side: monitor pops the scoreboard
  initial begin
    int lat = 0;
    bit got;
    logic [AW-1:0] a;
    wexp_t e;
    forever begin
      @(negedge clk); #1;
      if (rst_n && s_awvalid && s_wvalid) begin
        a = s_awaddr;
        n_swr++;
        if (wq.size() == 0) chk(0, "R4 extra wide write", s_awaddr, 0);
        else begin
          e = wq.pop_front();
          chk(s_awaddr == e.a, "R1 write addr", s_awaddr, e.a);
          chk(s_wdata == e.d, "R2 write data lane", s_wdata, e.d);
          chk(s_wstrb == e.s, "R3 write strobe lane", s_wstrb, e.s);
        end
        repeat (lat) @(negedge clk);
        lat = (lat + 1) % 3;
        s_awready = 1; s_wready = 1;
        @(negedge clk);
        s_awready = 0; s_wready = 0;
        s_bvalid = 1; s_bresp = resp_of(a);
        got = 0;
        while (!got) begin #1; got = s_bready; @(negedge clk); end
        s_bvalid = 0;
      end
    end
  end

  // slave read side
  initial begin
    int lat = 1;
    bit got;
    logic [AW-1:0] a, ea;
    forever begin
      @(negedge clk); #1;
      if (rst_n && s_arvalid) begin
        a = s_araddr;
        n_srd++;
        if (arq.size() == 0) chk(0, "R4 extra wide read", a, 0);
        else begin
          ea = arq.pop_front();
          chk(a == ea, "R1 read addr", a, ea);
        end
        repeat (lat) @(negedge clk);
        lat = (lat + 1) % 3;
        s_arready = 1;
        @(negedge clk);
        s_arready = 0;
        while (rd_stall) @(negedge clk);
        s_rvalid = 1; s_rdata = rfn(a); s_rresp = resp_of(a);
        got = 0;
        while (!got) begin #1; got = s_rready; @(negedge clk); end
        s_rvalid = 0; s_rdata = '0;
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(m_awready && m_wready && m_arready, "R9 readies after reset", {m_awready, m_wready, m_arready}, 3'b111);
    chk(!(m_bvalid || m_rvalid || s_awvalid || s_wvalid || s_arvalid), "R9 valids after reset",
        {m_bvalid, m_rvalid, s_awvalid, s_wvalid, s_arvalid}, 0);

    // R2 R3: full, partial and out-of-order lanes
    m_write(32'h0000, 16'h1111, 2'b11);
    m_write(32'h0002, 16'h2222, 2'b11);
    m_write(32'h0006, 16'h3333, 2'b11);
    m_write(32'h0004, 16'h4444, 2'b01);
    m_write(32'h0102, 16'h5555, 2'b01);
    m_write(32'h0100, 16'habcd, 2'b10);
    m_write(32'h0202, 16'h0f0f, 2'b00);
    // R4 R5: repeated reads to one wide word, out of order
    m_read(32'h0000);
    m_read(32'h0002);
    m_read(32'h0006);
    m_read(32'h0004);
    m_read(32'h0102);
    m_read(32'h0300);
    m_read(32'h0302);

    // R7 R8: write completes while a read response is stalled
    rd_stall = 1;
    fork
      m_read(32'h0206);
      begin
        repeat (2) @(negedge clk);
        m_write(32'h0306, 16'h7e7e, 2'b11);
        repeat (2) @(negedge clk); #1;
        chk(rd_busy, "R7 write done during pending read", rd_busy, 1);
        chk(!m_arready, "R8 no read accepted while pending", m_arready, 0);
        rd_stall = 0;
      end
    join

    repeat (10) @(negedge clk);
    chk(n_swr == n_mwr, "R4 one wide write per narrow write", n_swr, n_mwr);
    chk(n_srd == n_mrd, "R4 one wide read per narrow read", n_srd, n_mrd);
    chk(wq.size() == 0 && arq.size() == 0, "R4 scoreboard drained", wq.size() + arq.size(), 0);
    finish_run();
  end
endmodule